// File: doc/BRIEF.md
# Pipeline Exception Priority Controller

This block sits next to a five-stage in-order pipeline and decides, in each cycle, whether an exception is taken and which one. Each of the four front stages (fetch, decode, execute, memory) can raise a synchronous fault together with the address of the instruction it holds. Two asynchronous sources, an I/O request and a hardware-malfunction alarm, can arrive in any cycle. When several requests coincide, the fault of the instruction furthest down the pipeline wins, because that instruction is the oldest in program order. Any synchronous fault is taken ahead of an asynchronous one.

The requests are sampled on a clock edge. During the following cycle the block pulses the Cause and EPC write strobes, steers the PC selector to the fixed handler vector, and pulses one flush line for each stage at or younger than the faulting one. Older instructions carry on and retire. A trap flushes the faulting instruction where it stands. An interrupt is taken between instructions: only the fetch slot, which holds an instruction not yet issued, is discarded, and its address becomes the resume point. All pins are plain control and status levels. The block has no streaming interface and so no back-pressure.

Top module: `exc_prio_ctrl`

## Requirements
- R1: After reset, cause_o and epc_o are 0, and cause_wr_o, epc_wr_o, pc_sel_o and every flush_o bit are 0.
- R2: Among synchronous faults raised together, the oldest stage wins, in the order memory, execute, decode, fetch.
- R3: The cause code written is 0 for an I/O interrupt, 1 for a fetch page fault, 2 for a data page fault, 3 for an undefined instruction, 4 for an overflow and 5 for a hardware malfunction.
- R4: For a synchronous fault, epc_o takes the PC input of the winning stage.
- R5: The flush_o bit order is bit0 fetch, bit1 decode, bit2 execute, bit3 memory. A taken trap sets the bit of the faulting stage and every lower bit, and clears every bit above it.
- R6: If a synchronous fault and an asynchronous request are raised in the same cycle, the synchronous fault is taken.
- R7: A taken interrupt sets only flush_o bit0 and loads epc_o with pc_if_i. A hardware malfunction takes precedence over an I/O request.
- R8: Requests sampled on edge N cause cause_wr_o, epc_wr_o, pc_sel_o and the flush mask to be high for exactly the cycle after edge N. handler_pc_o is always 32'h8000_0180.
- R9: Requests present during a cycle in which any flush_o bit is high are ignored: they produce no strobe in the next cycle and leave cause_o and epc_o unchanged.
- R10: cause_o and epc_o change only in a cycle where their write strobe is high, and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| if_fault_i | input | 1 | Instruction page fault in fetch |
| id_undef_i | input | 1 | Undefined instruction in decode |
| ex_ovf_i | input | 1 | Arithmetic overflow in execute |
| mem_fault_i | input | 1 | Data page fault in memory |
| pc_if_i | input | 32 | PC of the instruction in fetch |
| pc_id_i | input | 32 | PC of the instruction in decode |
| pc_ex_i | input | 32 | PC of the instruction in execute |
| pc_mem_i | input | 32 | PC of the instruction in memory |
| io_irq_i | input | 1 | Asynchronous I/O request |
| hw_err_i | input | 1 | Asynchronous hardware malfunction |
| cause_o | output | 3 | Cause register |
| cause_wr_o | output | 1 | Cause write strobe |
| epc_o | output | 32 | Exception PC register |
| epc_wr_o | output | 1 | EPC write strobe |
| pc_sel_o | output | 1 | Selects the handler vector as next PC |
| handler_pc_o | output | 32 | Handler vector |
| flush_o | output | 4 | Per-stage flush pulses, bit0 fetch to bit3 memory |

## Verification
Two pairs of events can land in the same cycle. The first pair is a synchronous trap and an asynchronous interrupt. The bench raises both in one sampled cycle and expects the trap's cause code, EPC and flush mask. The second pair is a flush in progress and a fresh request. The bench holds a new fault asserted through the cycle in which the previous flush pulse is high, then checks that no strobe follows and that Cause and EPC still hold the earlier values.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int NSTG = 4;
  localparam int XLEN = 32;
  localparam int CW   = 3;

  typedef enum logic [CW-1:0] {
    C_IRQ   = 3'd0,
    C_IPF   = 3'd1,
    C_DPF   = 3'd2,
    C_UNDEF = 3'd3,
    C_OVF   = 3'd4,
    C_HWERR = 3'd5
  } cause_e;

  // stage index 0 = fetch ... 3 = memory
  function automatic cause_e stage_cause(int s);
    case (s)
      0:       return C_IPF;
      1:       return C_UNDEF;
      2:       return C_OVF;
      default: return C_DPF;
    endcase
  endfunction
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
#(
  parameter int N  = NSTG,
  parameter int W  = XLEN,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]        sync_req,
  input  logic [N-1:0][W-1:0] stage_pc,
  input  logic                io_irq,
  input  logic                hw_err,
  output logic                hit,
  output logic                is_sync,
  output cause_e              win_cause,
  output logic [W-1:0]        win_pc,
  output logic [SW-1:0]       win_stg
);
  always_comb begin
    is_sync   = |sync_req;
    hit       = is_sync | io_irq | hw_err;
    win_cause = hw_err ? C_HWERR : C_IRQ;
    win_pc    = stage_pc[0];
    win_stg   = '0;
    // later (older) stages overwrite earlier ones
    for (int s = 0; s < N; s++) begin
      if (sync_req[s]) begin
        win_cause = stage_cause(s);
        win_pc    = stage_pc[s];
        win_stg   = SW'(s);
      end
    end
  end
endmodule

// File: rtl/exc_flush_gen.sv
module exc_flush_gen #(
  parameter int N  = 4,
  localparam int SW = $clog2(N)
) (
  input  logic          fire,
  input  logic [SW-1:0] stg,
  output logic [N-1:0]  mask
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign mask[i] = fire & (stg >= SW'(i));
  end
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_pkg::*;
#(
  parameter int N = NSTG,
  parameter int W = XLEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  cause_e        cause_d,
  input  logic [W-1:0]  pc_d,
  input  logic [N-1:0]  mask_d,
  output logic [CW-1:0] cause_q,
  output logic [W-1:0]  epc_q,
  output logic          cause_wr,
  output logic          epc_wr,
  output logic          pc_sel,
  output logic [N-1:0]  flush
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q  <= '0;
      epc_q    <= '0;
      cause_wr <= 1'b0;
      epc_wr   <= 1'b0;
      pc_sel   <= 1'b0;
      flush    <= '0;
    end else begin
      cause_wr <= take;
      epc_wr   <= take;
      pc_sel   <= take;
      flush    <= take ? mask_d : '0;
      if (take) begin
        cause_q <= cause_d;
        epc_q   <= pc_d;
      end
    end
  end

  // R8
  flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|flush) |=> (flush == '0));
  // R10
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cause_wr |-> $stable(cause_q));
  // R10
  epc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !epc_wr |-> $stable(epc_q));
  // R5
  flush_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|flush) |-> (flush[0] && pc_sel));
endmodule

// File: rtl/exc_prio_ctrl.sv
module exc_prio_ctrl
  import exc_pkg::*;
#(
  parameter logic [XLEN-1:0] HANDLER = 32'h8000_0180
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            if_fault_i,
  input  logic            id_undef_i,
  input  logic            ex_ovf_i,
  input  logic            mem_fault_i,
  input  logic [XLEN-1:0] pc_if_i,
  input  logic [XLEN-1:0] pc_id_i,
  input  logic [XLEN-1:0] pc_ex_i,
  input  logic [XLEN-1:0] pc_mem_i,
  input  logic            io_irq_i,
  input  logic            hw_err_i,
  output logic [CW-1:0]   cause_o,
  output logic            cause_wr_o,
  output logic [XLEN-1:0] epc_o,
  output logic            epc_wr_o,
  output logic            pc_sel_o,
  output logic [XLEN-1:0] handler_pc_o,
  output logic [NSTG-1:0] flush_o
);
  localparam int SW = $clog2(NSTG);

  logic [NSTG-1:0]           sync_req;
  logic [NSTG-1:0][XLEN-1:0] stage_pc;
  logic                      hit, is_sync, take;
  cause_e                    win_cause;
  logic [XLEN-1:0]           win_pc;
  logic [SW-1:0]             win_stg;
  logic [NSTG-1:0]           mask;

  assign sync_req = {mem_fault_i, ex_ovf_i, id_undef_i, if_fault_i};
  assign stage_pc = {pc_mem_i, pc_ex_i, pc_id_i, pc_if_i};

  exc_arbiter #(.N(NSTG), .W(XLEN)) u_arb (
    .sync_req (sync_req),
    .stage_pc (stage_pc),
    .io_irq   (io_irq_i),
    .hw_err   (hw_err_i),
    .hit      (hit),
    .is_sync  (is_sync),
    .win_cause(win_cause),
    .win_pc   (win_pc),
    .win_stg  (win_stg)
  );

  // requests seen while a flush is applied are dropped
  assign take = hit & ~(|flush_o);

  exc_flush_gen #(.N(NSTG)) u_flush (
    .fire(1'b1),
    .stg (win_stg),
    .mask(mask)
  );

  exc_regs #(.N(NSTG), .W(XLEN)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .cause_d (win_cause),
    .pc_d    (win_pc),
    .mask_d  (mask),
    .cause_q (cause_o),
    .epc_q   (epc_o),
    .cause_wr(cause_wr_o),
    .epc_wr  (epc_wr_o),
    .pc_sel  (pc_sel_o),
    .flush   (flush_o)
  );

  assign handler_pc_o = HANDLER;

  // R6
  sync_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sync && !(|flush_o)) |=>
      (cause_wr_o && cause_o != C_IRQ && cause_o != C_HWERR));
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|flush_o) |=> (!cause_wr_o && !epc_wr_o));
  // R7
  irq_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !is_sync && !(|flush_o)) |=> (flush_o == NSTG'(1)));
endmodule

// File: tb/exc_prio_ctrl_tb.sv
module exc_prio_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        if_f = 0, id_u = 0, ex_o = 0, mem_f = 0, io = 0, hw = 0;
  logic [31:0] pif = 32'h0000_1010, pid = 32'h0000_100C;
  logic [31:0] pex = 32'h0000_1008, pmem = 32'h0000_1004;
  logic [2:0]  cause;
  logic        cwr, ewr, psel;
  logic [31:0] epc, hpc;
  logic [3:0]  flush;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  exc_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .if_fault_i(if_f), .id_undef_i(id_u), .ex_ovf_i(ex_o), .mem_fault_i(mem_f),
    .pc_if_i(pif), .pc_id_i(pid), .pc_ex_i(pex), .pc_mem_i(pmem),
    .io_irq_i(io), .hw_err_i(hw),
    .cause_o(cause), .cause_wr_o(cwr), .epc_o(epc), .epc_wr_o(ewr),
    .pc_sel_o(psel), .handler_pc_o(hpc), .flush_o(flush)
  );

  // {req io,hw,mem,ex,id,if}, cause, flush mask, EPC stage index
  localparam logic [14:0] VEC [14] = '{
    {6'b000001, 3'd1, 4'b0001, 2'd0},
    {6'b000010, 3'd3, 4'b0011, 2'd1},
    {6'b000100, 3'd4, 4'b0111, 2'd2},
    {6'b001000, 3'd2, 4'b1111, 2'd3},
    {6'b000011, 3'd3, 4'b0011, 2'd1},
    {6'b000110, 3'd4, 4'b0111, 2'd2},
    {6'b001111, 3'd2, 4'b1111, 2'd3},
    {6'b000101, 3'd4, 4'b0111, 2'd2},
    {6'b100000, 3'd0, 4'b0001, 2'd0},
    {6'b010000, 3'd5, 4'b0001, 2'd0},
    {6'b110000, 3'd5, 4'b0001, 2'd0},
    {6'b100001, 3'd1, 4'b0001, 2'd0},
    {6'b010100, 3'd4, 4'b0111, 2'd2},
    {6'b111000, 3'd2, 4'b1111, 2'd3}
  };

  function automatic logic [31:0] stage_pc(logic [1:0] s);
    case (s)
      2'd0: return 32'h0000_1010;
      2'd1: return 32'h0000_100C;
      2'd2: return 32'h0000_1008;
      default: return 32'h0000_1004;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [5:0] r);
    {io, hw, mem_f, ex_o, id_u, if_f} = r;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cause", {29'd0, cause}, 32'd0);
    check("R1 epc", epc, 32'd0);
    check("R1 strobes", {28'd0, cwr, ewr, psel, 1'b0}, 32'd0);
    check("R1 flush", {28'd0, flush}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 14; i++) begin
      logic [14:0] v;
      v = VEC[i];
      drive(v[14:9]);
      @(negedge clk);
      // R2 R3 R6 R7 cause; R4 R7 epc; R5 R7 flush; R8 strobes
      check($sformatf("R3 cause vec%0d", i), {29'd0, cause}, {29'd0, v[8:6]});
      check($sformatf("R4 epc vec%0d", i), epc, stage_pc(v[1:0]));
      check($sformatf("R5 flush vec%0d", i), {28'd0, flush}, {28'd0, v[5:2]});
      check($sformatf("R8 strobes vec%0d", i), {29'd0, cwr, ewr, psel}, 32'd7);
      check($sformatf("R8 handler vec%0d", i), hpc, 32'h8000_0180);
      drive(6'd0);
      @(negedge clk);
      check($sformatf("R8 pulse end vec%0d", i), {28'd0, cwr, ewr, psel, 1'b0} | {28'd0, flush}, 32'd0);
      check($sformatf("R10 hold vec%0d", i), {29'd0, cause}, {29'd0, v[8:6]});
    end

    // R9: a request held through the flush cycle is dropped
    drive(6'b001000);
    @(negedge clk);
    check("R9 first taken", {29'd0, cause}, 32'd2);
    drive(6'b000100);
    pex = 32'h0000_2222;
    @(negedge clk);
    check("R9 no strobe", {29'd0, cwr, ewr, psel}, 32'd0);
    check("R9 cause kept", {29'd0, cause}, 32'd2);
    check("R9 epc kept", epc, 32'h0000_1004);
    drive(6'd0);
    @(negedge clk);
    // R10: inputs moving without requests leave registers unchanged
    pif = 32'hDEAD_0000; pmem = 32'hBEEF_0000;
    repeat (2) @(negedge clk);
    check("R10 epc idle", epc, 32'h0000_1004);
    check("R10 cause idle", {29'd0, cause}, 32'd2);
    // R7: interrupt resumes at fetch PC
    drive(6'b100000);
    @(negedge clk);
    check("R7 irq epc", epc, 32'hDEAD_0000);
    check("R7 irq flush", {28'd0, flush}, 32'd1);
    drive(6'd0);
    @(negedge clk);
    // R1 reset mid-run clears state
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset again", epc, 32'd0);
    finish_run();
  end
endmodule